// File: doc/BRIEF.md
# Write Leveling Result Recovery

This block converts the raw per-lane delay that the PHY returns after a write-leveling run into the final write DQS delay for that lane. It takes the seed that was programmed into the lane before training. When seed adjustment is active, the seed's gross field was rewritten into an odd or even pre-gross code. The block restores the gross delay that this code removed, clamps or keeps results that come out negative, and folds every negative result into a running signed minimum.

A controller presents one lane result per strobe: the seed, the measured value and three mode flags. One cycle later the block returns the final 8-bit delay and an out-of-range flag. The flag marks a result that lies more than 0x20 away from the seed. The signed critical minimum is carried across lanes and DIMMs. A clear input returns it to zero at the start of each channel.

Top module: `wl_result_recover`

## Requirements
- R1: With seed adjust on and seed bit 5 = 1, the final delay is (meas + (seed & 0xE0) − 0x20) mod 256. If negative delays are allowed and seed bit 7 = 1, the final delay is instead (meas − 0x40) mod 256, and the signed value meas − 64 is offered to the critical minimum.
- R2: With seed adjust on, seed bit 5 = 0, seed bits 7:5 = 0 and meas < 0x40, the final delay is 0 when negative delays are disallowed. When they are allowed, the final delay is (meas − 0x40) mod 256 and meas − 64 is offered to the critical minimum.
- R3: With seed adjust on and seed bit 5 = 0, every other case gives a final delay of (meas + (seed & 0xE0) − 0x40) mod 256. When early DQ/DQS mode is on, the signed value ((meas + (seed & 0xE0)) mod 256) − 64 is offered to the critical minimum.
- R4: With seed adjust off, the final delay is 0 when seed bits 7:5 = 0 and meas bits 7:5 = 3. In every other case it is meas unchanged, and nothing is offered to the critical minimum.
- R5: The out-of-range flag is 1 exactly when negative delays are disallowed and the final delay and the seed, taken as unsigned integers, differ by more than 0x20.
- R6: The critical minimum is a signed 16-bit register. On each strobe it becomes the smaller of the offered value and its prior value. The clear input sets the base to 0, and a strobe in the same cycle is compared against that 0. The register never rises except through a clear.
- R7: The final delay and the out-of-range flag update on the clock edge that samples a strobe. The valid output is high during the following cycle only. Without a strobe, the final delay and the flag hold their values.
- R8: Synchronous reset sets the final delay, the flag, the valid output and the critical minimum to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: one lane result presented |
| seed | input | 8 | Seed programmed for the lane |
| meas | input | 8 | Raw delay measured by the PHY |
| seed_adj_en | input | 1 | Seed was pre-gross encoded |
| neg_ok | input | 1 | Negative delays allowed |
| early_mode | input | 1 | Early DQ/DQS mode active |
| crit_clr | input | 1 | Clear the critical minimum to 0 |
| out_valid | output | 1 | Result valid pulse |
| final_dly | output | 8 | Recovered write DQS delay |
| out_of_range | output | 1 | Result outside the window around the seed |
| crit_min | output | 16 | Signed most negative delay seen |

## Verification
A wrong branch in gross restoration shows as a wrong final delay in the cycle right after the strobe. A wrong flag polarity shows the same way, and the checks use seed and measurement pairs that reach every odd, even, zero-gross and unadjusted case. A fault in the critical tracker may appear only later, once a more negative lane arrives or a clear coincides with a strobe. The bench therefore runs long sequences without clears and compares the tracker after every lane.

// File: rtl/wl_rec_pkg.sv
package wl_rec_pkg;
    localparam int DLY_W    = 8;
    localparam int CRIT_W   = 16;
    localparam int GROSS_LSB = 5;
    localparam logic [DLY_W-1:0] GROSS_MASK = 8'hE0;
    localparam logic [DLY_W-1:0] ONE_GROSS  = 8'h20;
    localparam logic [DLY_W-1:0] TWO_GROSS  = 8'h40;
    localparam int WINDOW   = 32;

    typedef struct packed {
        logic                     adj;
        logic                     neg_ok;
        logic                     early;
    } wl_mode_t;

    typedef struct packed {
        logic [DLY_W-1:0]         dly;
        logic                     cand_vld;
        logic signed [CRIT_W-1:0] cand;
    } wl_res_t;

    function automatic logic signed [CRIT_W-1:0] sext_minus(input logic [DLY_W:0] v);
        return $signed({{(CRIT_W-DLY_W-1){1'b0}}, v}) - $signed(CRIT_W'(64));
    endfunction

    function automatic logic [2:0] gross_of(input logic [DLY_W-1:0] v);
        return v[DLY_W-1:GROSS_LSB];
    endfunction
endpackage

// File: rtl/wl_gross_restore.sv
module wl_gross_restore
    import wl_rec_pkg::*;
(
    input  logic [DLY_W-1:0] seed,
    input  logic [DLY_W-1:0] meas,
    input  wl_mode_t         mode,
    output wl_res_t          res
);
    logic [DLY_W-1:0] seed_gross;
    logic [DLY_W-1:0] sum8;
    logic             seed_odd;
    logic             seed_g0;

    always_comb begin
        seed_gross = seed & GROSS_MASK;
        sum8       = meas + seed_gross;
        seed_odd   = seed[GROSS_LSB];
        seed_g0    = (gross_of(seed) == 3'd0);
        res        = '0;
        res.dly    = meas;
        if (mode.adj) begin
            if (seed_odd) begin
                if (mode.neg_ok && seed[DLY_W-1]) begin
                    res.dly      = meas - TWO_GROSS;
                    res.cand_vld = 1'b1;
                    res.cand     = sext_minus({1'b0, meas});
                end else begin
                    res.dly = sum8 - ONE_GROSS;
                end
            end else if (seed_g0 && (meas < TWO_GROSS)) begin
                if (mode.neg_ok) begin
                    res.dly      = meas - TWO_GROSS;
                    res.cand_vld = 1'b1;
                    res.cand     = sext_minus({1'b0, meas});
                end else begin
                    res.dly = '0;
                end
            end else begin
                res.dly = sum8 - TWO_GROSS;
                if (mode.early) begin
                    res.cand_vld = 1'b1;
                    res.cand     = sext_minus({1'b0, sum8});
                end
            end
        end else if (seed_g0 && (gross_of(meas) == 3'd3)) begin
            res.dly = '0;
        end
    end
endmodule

// File: rtl/wl_range_check.sv
module wl_range_check
    import wl_rec_pkg::*;
(
    input  logic [DLY_W-1:0] seed,
    input  logic [DLY_W-1:0] dly,
    input  logic             neg_ok,
    output logic             oor
);
    logic [DLY_W:0] s_ext;
    logic [DLY_W:0] d_ext;

    always_comb begin
        s_ext = {1'b0, seed};
        d_ext = {1'b0, dly};
        oor   = !neg_ok &&
                ((d_ext > s_ext + (DLY_W+1)'(WINDOW)) || (s_ext > d_ext + (DLY_W+1)'(WINDOW)));
    end
endmodule

// File: rtl/wl_crit_tracker.sv
module wl_crit_tracker
    import wl_rec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     upd,
    input  logic signed [CRIT_W-1:0] cand,
    output logic signed [CRIT_W-1:0] crit
);
    logic signed [CRIT_W-1:0] base;
    logic signed [CRIT_W-1:0] nxt;

    always_comb begin
        base = clr ? '0 : crit;
        nxt  = base;
        if (upd && (cand < base)) nxt = cand;
    end

    always_ff @(posedge clk) begin
        if (rst) crit <= '0;
        else     crit <= nxt;
    end
endmodule

// File: rtl/wl_result_recover.sv
module wl_result_recover
    import wl_rec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [7:0]               seed,
    input  logic [7:0]               meas,
    input  logic                     seed_adj_en,
    input  logic                     neg_ok,
    input  logic                     early_mode,
    input  logic                     crit_clr,
    output logic                     out_valid,
    output logic [7:0]               final_dly,
    output logic                     out_of_range,
    output logic signed [15:0]       crit_min
);
    wl_mode_t mode;
    wl_res_t  res;
    logic     oor_c;

    assign mode = '{adj: seed_adj_en, neg_ok: neg_ok, early: early_mode};

    wl_gross_restore u_restore (
        .seed (seed),
        .meas (meas),
        .mode (mode),
        .res  (res)
    );

    wl_range_check u_range (
        .seed   (seed),
        .dly    (res.dly),
        .neg_ok (neg_ok),
        .oor    (oor_c)
    );

    wl_crit_tracker u_crit (
        .clk  (clk),
        .rst  (rst),
        .clr  (crit_clr),
        .upd  (in_valid && res.cand_vld),
        .cand (res.cand),
        .crit (crit_min)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            final_dly    <= '0;
            out_of_range <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                final_dly    <= res.dly;
                out_of_range <= oor_c;
            end
        end
    end
endmodule

// File: rtl/wl_result_recover_chk.sv
module wl_result_recover_chk (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [7:0]         seed,
    input logic [7:0]         meas,
    input logic               seed_adj_en,
    input logic               neg_ok,
    input logic               crit_clr,
    input logic               out_valid,
    input logic [7:0]         final_dly,
    input logic               out_of_range,
    input logic signed [15:0] crit_min
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(final_dly) && $stable(out_of_range))); // R7
    AST_CRIT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !crit_clr |=> (crit_min <= $past(crit_min))); // R6
    AST_CRIT_NONPOS: assert property (@(posedge clk) disable iff (rst)
        crit_min <= 16'sd0); // R6
    AST_NEG_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && neg_ok) |=> !out_of_range); // R5
    AST_NOADJ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !seed_adj_en && seed[7:5] == 3'd0 && meas[7:5] == 3'd3) |=> (final_dly == 8'd0)); // R4
endmodule

bind wl_result_recover wl_result_recover_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .seed         (seed),
    .meas         (meas),
    .seed_adj_en  (seed_adj_en),
    .neg_ok       (neg_ok),
    .crit_clr     (crit_clr),
    .out_valid    (out_valid),
    .final_dly    (final_dly),
    .out_of_range (out_of_range),
    .crit_min     (crit_min)
);

// File: tb/sim_wl_result_recover.sv
module sim_wl_result_recover;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        seed = '0;
    logic [7:0]        meas = '0;
    logic              seed_adj_en = 1'b0;
    logic              neg_ok = 1'b0;
    logic              early_mode = 1'b0;
    logic              crit_clr = 1'b0;
    logic              out_valid;
    logic [7:0]        final_dly;
    logic              out_of_range;
    logic signed [15:0] crit_min;

    int total = 0;
    int bad = 0;
    int model_crit = 0;
    int exp_dly = 0;
    bit exp_oor = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wl_result_recover u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .seed(seed), .meas(meas),
        .seed_adj_en(seed_adj_en), .neg_ok(neg_ok), .early_mode(early_mode),
        .crit_clr(crit_clr), .out_valid(out_valid), .final_dly(final_dly),
        .out_of_range(out_of_range), .crit_min(crit_min)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: returns final delay, sets candidate (cv=0 when none)
    function automatic int ref_dly(input int s, input int m, input bit adj, input bit nk,
                                   input bit er, output bit cv, output int cand);
        int g;
        int r;
        g = s / 32;
        cv = 0;
        cand = 0;
        if (!adj) begin
            r = (g == 0 && m / 32 == 3) ? 0 : m;
        end else if (g % 2 == 1) begin
            if (nk && s >= 128) begin
                r = (m - 64 + 256) % 256; cv = 1; cand = m - 64;
            end else begin
                r = (m + g * 32 - 32 + 256) % 256;
            end
        end else if (g == 0 && m < 64) begin
            if (nk) begin r = (m - 64 + 256) % 256; cv = 1; cand = m - 64; end
            else r = 0;
        end else begin
            r = (m + g * 32 - 64 + 256) % 256;
            if (er) begin cv = 1; cand = ((m + g * 32) % 256) - 64; end
        end
        return r;
    endfunction

    task automatic lane(input int s, input int m, input bit adj, input bit nk,
                        input bit er, input bit clr, input string req);
        bit cv;
        int cand;
        int diff;
        @(negedge clk);
        seed = s[7:0]; meas = m[7:0]; seed_adj_en = adj; neg_ok = nk;
        early_mode = er; crit_clr = clr; in_valid = 1'b1;
        exp_dly = ref_dly(s, m, adj, nk, er, cv, cand);
        diff = exp_dly - s;
        exp_oor = !nk && (diff > 32 || diff < -32);
        if (clr) model_crit = 0;
        if (cv && cand < model_crit) model_crit = cand;
        @(negedge clk);
        in_valid = 1'b0; crit_clr = 1'b0;
        chk({req, " dly"}, int'(final_dly), exp_dly);
        chk("R5 oor", int'(out_of_range), int'(exp_oor));
        chk("R6 crit", int'(crit_min), model_crit);
        chk("R7 valid", int'(out_valid), 1);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R8 reset dly", int'(final_dly), 0);
        chk("R8 reset crit", int'(crit_min), 0);
        chk("R8 reset valid", int'(out_valid), 0);
        chk("R8 reset oor", int'(out_of_range), 0);
        rst = 1'b0;
        // directed corners
        lane(8'h61, 8'h50, 1, 0, 0, 0, "R1 odd");
        lane(8'hA5, 8'h30, 1, 1, 0, 0, "R1 neg odd");
        lane(8'h10, 8'h20, 1, 0, 0, 0, "R2 clamp");
        lane(8'h10, 8'h05, 1, 1, 0, 0, "R2 neg");
        lane(8'h45, 8'h50, 1, 0, 0, 0, "R3 even");
        lane(8'h05, 8'h10, 1, 1, 1, 0, "R2 neg early");
        lane(8'h40, 8'h00, 1, 0, 1, 0, "R3 early");
        lane(8'h12, 8'h70, 0, 0, 0, 0, "R4 zero");
        lane(8'h12, 8'h90, 0, 0, 0, 0, "R4 pass");
        lane(8'h90, 8'h20, 0, 0, 0, 0, "R5 far");
        lane(8'h30, 8'h10, 1, 1, 0, 1, "R6 clr same");
        // R7: idle cycle holds outputs
        @(negedge clk);
        chk("R7 idle valid", int'(out_valid), 0);
        chk("R7 hold dly", int'(final_dly), exp_dly);
        chk("R7 hold oor", int'(out_of_range), int'(exp_oor));
        // random
        for (int i = 0; i < 400; i++) begin
            lane(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 15) == 0), "R1 R2 R3 R4 rand");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule